// File: doc/BRIEF.md
# Ingress Packet Priority Classifier

This block watches the opening bytes of each received frame as they stream past and assigns the frame a priority without stalling or buffering the stream. It first picks a 3-bit received priority from one of three sources. A VLAN tag supplies it directly. An IPv4 header with a 20-byte header supplies a DSCP code point, which is translated through a table owned by the receive port. Any other frame takes the receive port's default.

The received priority is then passed through two lookups. A per-port table turns it into a 3-bit header priority, which also serves as the priority written into an outgoing VLAN tag. A single shared table then reduces the header priority to one of four switch priority levels, where 3 is the most urgent.

All tables are loaded through a one-cycle write strobe. Results appear together with a one-cycle done pulse.

Top module: `prio_classifier`

## Requirements
- R1: After reset, out_done is low and both priority outputs are 0. The tables hold these values: DSCP entry d on every port maps to d[5:3], the priority-to-header table is the identity, header priority h maps to switch priority h[2:1], and every port default is 0.
- R2: When frame bytes 12 and 13 are 0x81 and 0x00 and byte 14 is present, the received priority is byte 14 bits [7:5].
- R3: When bytes 12 and 13 are 0x08 and 0x00, byte 14 is 0x45 and byte 15 is present, the received priority is the receive port's DSCP entry addressed by byte 15 bits [7:2].
- R4: Every other frame uses the receive port's default priority. This covers a frame type other than those two, an IPv4 frame whose byte 14 is not 0x45, and a frame that ends before the byte its rule needs.
- R5: out_hdr_prio equals the receive port's priority-to-header entry at the received priority, and out_sw_prio equals the shared header-to-switch entry at that header priority.
- R6: out_done pulses for exactly one cycle per frame, in the cycle after the beat carrying byte 15, or after the end-of-frame beat if that beat comes earlier. Bytes after byte 15 have no effect.
- R7: out_hdr_prio and out_sw_prio hold their values in every cycle in which out_done is low, including across table writes.
- R8: With cfg_we high, cfg_sel selects the table being written. 0 writes DSCP entry cfg_addr of port cfg_port. 1 writes priority-to-header entry cfg_addr[2:0] of port cfg_port. 2 writes switch entry cfg_addr[2:0] with cfg_data[1:0]. 3 writes the default of port cfg_port.
- R9: A start-of-frame beat carrying port number 3 begins no frame, and that frame produces no out_done. Such a beat also abandons any frame still in progress.
- R10: A start-of-frame beat arriving during an unfinished frame restarts classification at byte 0 for the new frame.
- R11: Cycles with in_valid low do not advance the byte position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_sof | input | 1 | This byte is byte 0 of a frame |
| in_eof | input | 1 | This byte is the last of the frame |
| in_port | input | 2 | Receive port, sampled on the start-of-frame beat |
| in_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select (see R8) |
| cfg_port | input | 2 | Port whose table is written |
| cfg_addr | input | 6 | Entry index |
| cfg_data | input | 3 | Entry value |
| out_done | output | 1 | One-cycle pulse: classification finished |
| out_hdr_prio | output | 3 | Header priority of the last classified frame |
| out_sw_prio | output | 2 | Switch priority of the last classified frame |

## Verification
The bench sends frames that stop at byte 14 and at byte 15, right at the edge of the VLAN and IPv4 rules. A design that reads stale bytes from the previous frame would pick a tag or DSCP priority where the port default is due.

Long frames with idle gaps check that only one done pulse is produced, on the correct cycle. A design that counted idle cycles or kept classifying past byte 15 would shift or repeat the pulse.

A frame is also abandoned in the middle by a new start-of-frame beat. A design that ignored the restart would classify the new frame from the wrong byte offsets.

Finally, port-3 frames and table writes made after a result check that the outputs stay still when nothing should move them.

// File: rtl/prio_classifier.sv
module prio_classifier #(
  parameter int NPORTS = 3,
  parameter int PW     = 2,
  parameter int RXW    = 3,
  parameter int SWW    = 2,
  parameter int DSCPW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [PW-1:0]    in_port,
  input  logic [7:0]       in_data,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [PW-1:0]    cfg_port,
  input  logic [DSCPW-1:0] cfg_addr,
  input  logic [RXW-1:0]   cfg_data,
  output logic             out_done,
  output logic [RXW-1:0]   out_hdr_prio,
  output logic [SWW-1:0]   out_sw_prio
);

  localparam int NRX   = 1 << RXW;
  localparam int NDSCP = 1 << DSCPW;
  localparam int IW    = 4;
  localparam logic [IW-1:0] POS_ET_HI = IW'(12);
  localparam logic [IW-1:0] POS_ET_LO = IW'(13);
  localparam logic [IW-1:0] POS_TAG   = IW'(14);
  localparam logic [IW-1:0] POS_TOS   = IW'(15);

  logic [RXW-1:0] dscp_t [NPORTS][NDSCP];
  logic [RXW-1:0] p2h_t  [NPORTS][NRX];
  logic [SWW-1:0] h2s_t  [NRX];
  logic [RXW-1:0] dflt_t [NPORTS];

  wire cfg_port_ok = {1'b0, cfg_port} < (PW+1)'(NPORTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) begin
        for (int d = 0; d < NDSCP; d++)
          dscp_t[p][d] <= RXW'(d >> (DSCPW - RXW));
        for (int r = 0; r < NRX; r++)
          p2h_t[p][r] <= RXW'(r);
        dflt_t[p] <= '0;
      end
      for (int r = 0; r < NRX; r++)
        h2s_t[r] <= SWW'(r >> (RXW - SWW));
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (cfg_port_ok) dscp_t[cfg_port][cfg_addr] <= cfg_data;
        2'd1: if (cfg_port_ok) p2h_t[cfg_port][cfg_addr[RXW-1:0]] <= cfg_data;
        2'd2: h2s_t[cfg_addr[RXW-1:0]] <= cfg_data[SWW-1:0];
        default: if (cfg_port_ok) dflt_t[cfg_port] <= cfg_data;
      endcase
    end
  end

  logic          active_q;
  logic [IW-1:0] idx_q;
  logic [PW-1:0] port_q;
  logic [7:0]    et_hi_q, et_lo_q, tag_q;

  wire in_port_ok = {1'b0, in_port} < (PW+1)'(NPORTS);
  wire start      = in_valid && in_sof && in_port_ok;
  wire beat       = start || (in_valid && !in_sof && active_q);

  wire [IW-1:0] idx  = start ? '0 : idx_q;
  wire [PW-1:0] port = start ? in_port : port_q;
  wire          last = beat && (idx == POS_TOS || in_eof);

  wire [7:0]  tag    = (idx == POS_TAG) ? in_data : tag_q;
  wire [15:0] etype  = {et_hi_q, et_lo_q};
  wire        is_tag = (idx >= POS_TAG) && (etype == 16'h8100);
  wire        is_ip4 = (idx == POS_TOS) && (etype == 16'h0800) && (tag == 8'h45);

  logic [RXW-1:0] rx_prio;
  always_comb begin
    if (is_tag)      rx_prio = tag[7 -: RXW];
    else if (is_ip4) rx_prio = dscp_t[port][in_data[7 -: DSCPW]];
    else             rx_prio = dflt_t[port];
  end

  wire [RXW-1:0] hdr_prio = p2h_t[port][rx_prio];
  wire [SWW-1:0] sw_prio  = h2s_t[hdr_prio];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      port_q   <= '0;
      et_hi_q  <= '0;
      et_lo_q  <= '0;
      tag_q    <= '0;
    end else begin
      if (in_valid && in_sof && !in_port_ok) active_q <= 1'b0;
      else if (beat)                         active_q <= !last;
      if (beat) begin
        idx_q  <= idx + 1'b1;
        port_q <= port;
        if (idx == POS_ET_HI) et_hi_q <= in_data;
        if (idx == POS_ET_LO) et_lo_q <= in_data;
        if (idx == POS_TAG)   tag_q   <= in_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done     <= 1'b0;
      out_hdr_prio <= '0;
      out_sw_prio  <= '0;
    end else begin
      out_done <= last;
      if (last) begin
        out_hdr_prio <= hdr_prio;
        out_sw_prio  <= sw_prio;
      end
    end
  end

endmodule

// File: rtl/prio_classifier_chk.sv
module prio_classifier_chk #(
  parameter int NPORTS = 3,
  parameter int PW     = 2,
  parameter int RXW    = 3,
  parameter int SWW    = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_sof,
  input logic           in_eof,
  input logic [PW-1:0]  in_port,
  input logic           out_done,
  input logic [RXW-1:0] out_hdr_prio,
  input logic [SWW-1:0] out_sw_prio
);

  wire good_port = {1'b0, in_port} < (PW+1)'(NPORTS);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_done);

  a_r6_done_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> $past(in_valid));

  a_r6_one_byte_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_eof && good_port) |=> out_done);

  a_r9_bad_port_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !good_port) |=> !out_done);

  a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> ($stable(out_hdr_prio) && $stable(out_sw_prio)));

endmodule

bind prio_classifier prio_classifier_chk #(
  .NPORTS(NPORTS), .PW(PW), .RXW(RXW), .SWW(SWW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .in_port(in_port), .out_done(out_done),
  .out_hdr_prio(out_hdr_prio), .out_sw_prio(out_sw_prio)
);

// File: tb/test_prio_classifier.sv
module test_prio_classifier;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       in_valid = 0, in_sof = 0, in_eof = 0;
  logic [1:0] in_port = 0;
  logic [7:0] in_data = 0;
  logic       cfg_we = 0;
  logic [1:0] cfg_sel = 0, cfg_port = 0;
  logic [5:0] cfg_addr = 0;
  logic [2:0] cfg_data = 0;
  logic       out_done;
  logic [2:0] out_hdr_prio;
  logic [1:0] out_sw_prio;

  int n_checks = 0, n_fail = 0;
  logic [2:0] dscp_m [3][64];
  logic [2:0] p2h_m  [3][8];
  logic [1:0] h2s_m  [8];
  logic [2:0] def_m  [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_classifier i_prio_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_port(in_port), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_port(cfg_port),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .out_done(out_done),
    .out_hdr_prio(out_hdr_prio), .out_sw_prio(out_sw_prio)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int port, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_port = 2'(port);
    cfg_addr = 6'(addr); cfg_data = 3'(data);
    if (port < 3) begin
      if (sel == 0) dscp_m[port][addr] = 3'(data);
      if (sel == 1) p2h_m[port][addr % 8] = 3'(data);
      if (sel == 3) def_m[port] = 3'(data);
    end
    if (sel == 2) h2s_m[addr % 8] = 2'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic int exp_rx(int port, int len, logic [7:0] b12, b13, b14, b15);
    if (len >= 15 && b12 == 8'h81 && b13 == 8'h00) return int'(b14[7:5]);
    if (len >= 16 && b12 == 8'h08 && b13 == 8'h00 && b14 == 8'h45)
      return int'(dscp_m[port][b15[7:2]]);
    return int'(def_m[port]);
  endfunction

  task automatic send(input string req, input int port, input int len,
                      input logic [7:0] b12, b13, b14, b15,
                      input bit gaps, input bit do_eof, input bit want_done);
    int ci;
    int ndone = 0;
    bit pend = 0, bad = 0;
    logic [2:0] got_h = 0;
    logic [1:0] got_s = 0;
    int rx, eh, es;
    ci = (len - 1 < 15) ? len - 1 : 15;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (out_done) begin ndone++; got_h = out_hdr_prio; got_s = out_sw_prio; end
      if (out_done !== pend) bad = 1;
      pend = 0;
      if (gaps && (i % 3 == 2)) begin
        in_valid = 0;
        @(negedge clk);
        if (out_done) ndone++;
        if (out_done !== pend) bad = 1;
      end
      in_valid = 1; in_sof = (i == 0); in_eof = do_eof && (i == len - 1);
      in_port = 2'(port);
      in_data = (i == 12) ? b12 : (i == 13) ? b13 : (i == 14) ? b14 :
                (i == 15) ? b15 : 8'(i + 8'h30);
      pend = want_done && (i == ci) && (do_eof || i == 15);
    end
    @(negedge clk);
    if (out_done) begin ndone++; got_h = out_hdr_prio; got_s = out_sw_prio; end
    if (out_done !== pend) bad = 1;
    in_valid = 0; in_sof = 0; in_eof = 0;
    @(negedge clk);
    if (out_done) ndone++;
    chk({req, " done timing"}, int'(bad), 0);
    chk({req, " done count"}, ndone, want_done ? 1 : 0);
    if (want_done) begin
      rx = exp_rx(port, len, b12, b13, b14, b15);
      eh = int'(p2h_m[port][rx]);
      es = int'(h2s_m[eh]);
      chk({req, " header prio"}, int'(got_h), eh);
      chk({req, " switch prio"}, int'(got_s), es);
    end
  endtask

  task automatic t_reset;
    chk("R1 done after reset", int'(out_done), 0);
    chk("R1 hdr after reset", int'(out_hdr_prio), 0);
    chk("R1 sw after reset", int'(out_sw_prio), 0);
  endtask

  task automatic t_vlan_default_tables;
    send("R2 R5 R1 vlan pcp5 p0", 0, 20, 8'h81, 8'h00, 8'hA7, 8'h11, 0, 1, 1);
    send("R2 vlan pcp7 p2", 2, 16, 8'h81, 8'h00, 8'hE0, 8'h00, 0, 1, 1);
  endtask

  task automatic t_programmed_maps;
    cfg(1, 1, 3, 6);
    cfg(2, 0, 6, 1);
    send("R5 R8 vlan mapped p1", 1, 18, 8'h81, 8'h00, 8'h60, 8'h00, 0, 1, 1);
  endtask

  task automatic t_ipv4;
    send("R3 R1 ipv4 default dscp", 0, 16, 8'h08, 8'h00, 8'h45, 8'hB8, 0, 1, 1);
    cfg(0, 2, 46, 2);
    send("R3 R8 ipv4 programmed dscp", 2, 24, 8'h08, 8'h00, 8'h45, 8'hB8, 0, 1, 1);
  endtask

  task automatic t_fallback;
    cfg(3, 0, 0, 6);
    send("R4 ipv4 bad ihl", 0, 16, 8'h08, 8'h00, 8'h46, 8'hFC, 0, 1, 1);
    send("R4 other type", 0, 16, 8'h86, 8'hDD, 8'h60, 8'h00, 0, 1, 1);
    send("R4 vlan cut at 14", 0, 14, 8'h81, 8'h00, 8'h00, 8'h00, 0, 1, 1);
    send("R2 vlan ends at 15", 0, 15, 8'h81, 8'h00, 8'h20, 8'h00, 0, 1, 1);
    send("R4 ipv4 ends at 15", 0, 15, 8'h08, 8'h00, 8'h45, 8'h00, 0, 1, 1);
    send("R6 R4 single byte", 0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1, 1);
  endtask

  task automatic t_long_gaps;
    send("R6 R11 long gapped vlan", 1, 40, 8'h81, 8'h00, 8'h80, 8'h00, 1, 1, 1);
    send("R11 R3 gapped ipv4", 2, 16, 8'h08, 8'h00, 8'h45, 8'hB8, 1, 1, 1);
  endtask

  task automatic t_bad_port;
    send("R9 port3 frame", 3, 16, 8'h81, 8'h00, 8'hE0, 8'h00, 0, 1, 0);
    send("R9 abandoned frame", 0, 10, 8'h81, 8'h00, 8'hE0, 8'h00, 0, 0, 0);
    send("R9 port3 abandons", 3, 3, 8'h00, 8'h00, 8'h00, 8'h00, 0, 1, 0);
  endtask

  task automatic t_restart;
    send("R10 partial frame", 0, 13, 8'h81, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    send("R10 restarted frame", 1, 16, 8'h81, 8'h00, 8'hC0, 8'h00, 0, 1, 1);
  endtask

  task automatic t_hold;
    logic [2:0] h;
    logic [1:0] s;
    send("R7 setup", 0, 16, 8'h81, 8'h00, 8'h40, 8'h00, 0, 1, 1);
    h = out_hdr_prio; s = out_sw_prio;
    cfg(1, 0, 2, 0);
    cfg(2, 0, 2, 3);
    repeat (3) @(negedge clk);
    chk("R7 hdr held", int'(out_hdr_prio), int'(h));
    chk("R7 sw held", int'(out_sw_prio), int'(s));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 64; d++) dscp_m[p][d] = 3'(d >> 3);
      for (int r = 0; r < 8; r++) p2h_m[p][r] = 3'(r);
      def_m[p] = 0;
    end
    for (int r = 0; r < 8; r++) h2s_m[r] = 2'(r >> 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vlan_default_tables();
    t_programmed_maps();
    t_ipv4();
    t_fallback();
    t_long_gaps();
    t_bad_port();
    t_restart();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule